// File: doc/BRIEF.md
# Programmable Product-Term Logic Block

This block is a configurable sum-of-products fabric. Thirty-six routed input signals are each offered to an AND array in both true and inverted form. The array builds a shared pool of 86 product terms, and each literal's participation in each term is set by a configuration bit. An allocator then gives every one of 16 macrocells up to sixteen selection slots. Each slot names one term from the pool. Any term may be named by several slots or by several macrocells at once, so common terms are built only once.

Each macrocell ORs the terms its enabled slots select and may invert the result. The pin output carries either that combinational value or a register fed by it. The feedback output also picks between the same two sources, but its choice is independent of the pin, so a register can stay in use internally while the pin shows something else. Each register is clocked by one of two global clocks. It has an active-low asynchronous clear and an active-low asynchronous preset, and the clear wins when both are low. All configuration arrives as static input vectors.

Top module: `ppt_logic_block`

## Requirements
- R1: Product term j is the AND of the literals enabled in `and_cfg[j*72 +: 72]`. In that field, bit 2i enables the true form of `sig_in[i]` and bit 2i+1 enables its complement.
- R2: A product term with no enabled literal evaluates to 1. A term that enables both forms of the same input evaluates to 0.
- R3: Macrocell m has 16 slots. Slot s takes its term index from `slot_idx[(m*16+s)*7 +: 7]` and its enable from `slot_en[m*16+s]`. The macrocell sum is the OR of the terms named by its enabled slots, and the sum is 0 when no slot is enabled.
- R4: An enabled slot whose index is 86 or more contributes 0 to the sum.
- R5: The same product term may be selected by several slots and several macrocells at the same time, and each of them sees the term's current value.
- R6: When `mc_inv[m]` is 1, the macrocell value is the sum inverted. The inversion is applied before the register, so the register captures the inverted value.
- R7: When `mc_pin_comb[m]` is 1, `pin_out[m]` follows the combinational value with no clock. When it is 0, `pin_out[m]` shows the register, which changes only on a capture edge or an asynchronous control.
- R8: When `mc_clk_sel[m]` is 0, the register captures on a rising `clk_a`; when it is 1, it captures on a rising `clk_b`. An edge of the unselected clock leaves the register unchanged.
- R9: When `mc_fb_reg[m]` is 1, `fb_out[m]` shows the register; when it is 0, `fb_out[m]` shows the combinational value. This choice is independent of the pin setting.
- R10: While `clr_n` is low, every register reads 0 at once, with no clock, even if `set_n` is also low.
- R11: While `set_n` is low and `clr_n` is high, every register reads 1 at once, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Global clock, selected by a 0 in `mc_clk_sel` |
| clk_b | input | 1 | Global clock, selected by a 1 in `mc_clk_sel` |
| clr_n | input | 1 | Asynchronous clear of all registers, active low, highest priority |
| set_n | input | 1 | Asynchronous preset of all registers, active low |
| sig_in | input | N_IN (36) | Routed logic inputs |
| and_cfg | input | 2*N_IN*N_PT (6192) | Literal enables, one 72-bit field per product term |
| slot_idx | input | N_MC*SLOTS*IDXW (1792) | Term index for each slot of each macrocell |
| slot_en | input | N_MC*SLOTS (256) | Enable for each slot |
| mc_inv | input | N_MC (16) | Per-macrocell polarity inversion |
| mc_pin_comb | input | N_MC (16) | Per-macrocell pin source: 1 combinational, 0 registered |
| mc_fb_reg | input | N_MC (16) | Per-macrocell feedback source: 1 registered, 0 combinational |
| mc_clk_sel | input | N_MC (16) | Per-macrocell clock choice: 0 `clk_a`, 1 `clk_b` |
| pin_out | output | N_MC (16) | Pin-path output of each macrocell |
| fb_out | output | N_MC (16) | Feedback output of each macrocell |

## Verification
The asynchronous clear and preset can both be active in the same interval, and either can coincide with a capture edge. The bench lowers the preset first, then lowers the clear while the preset is still held, and pulses `clk_a` during the preset alone. Registered pins must read 1 under the preset alone, even across the edge, and 0 once the clear joins in. The controls are released preset first, and the pins must stay at 0 until the next capture.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

  typedef enum logic {
    CLK_SRC_A = 1'b0,
    CLK_SRC_B = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic     inv;
    logic     pin_comb;
    logic     fb_reg;
    clk_src_e clk_src;
  } mc_cfg_t;

endpackage

// File: rtl/ppt_and_array.sv
module ppt_and_array #(
  parameter int N_IN = 36,
  parameter int N_PT = 86
) (
  input  logic [N_IN-1:0]          sig_in,
  input  logic [2*N_IN*N_PT-1:0]   and_cfg,
  output logic [N_PT-1:0]          terms
);

  localparam int N_COL = 2 * N_IN;

  logic [N_COL-1:0] cols;

  // true literal on even column, complement on odd column
  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign cols[2*i]   = sig_in[i];
      assign cols[2*i+1] = ~sig_in[i];
    end
  endgenerate

  // a column that is not enabled forces a 1 into the AND
  generate
    for (genvar j = 0; j < N_PT; j++) begin : g_term
      assign terms[j] = &(cols | ~and_cfg[j*N_COL +: N_COL]);
    end
  endgenerate

endmodule

// File: rtl/ppt_allocator.sv
module ppt_allocator #(
  parameter int N_PT  = 86,
  parameter int N_MC  = 16,
  parameter int SLOTS = 16,
  parameter int IDXW  = 7
) (
  input  logic [N_PT-1:0]            terms,
  input  logic [N_MC*SLOTS*IDXW-1:0] slot_idx,
  input  logic [N_MC*SLOTS-1:0]      slot_en,
  output logic [N_MC-1:0]            sums
);

  generate
    for (genvar m = 0; m < N_MC; m++) begin : g_mc
      logic [SLOTS-1:0] picked;
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [IDXW-1:0] idx;
        logic            in_range;
        assign idx      = slot_idx[(m*SLOTS+s)*IDXW +: IDXW];
        assign in_range = (int'(idx) < N_PT);
        always_comb begin
          if (slot_en[m*SLOTS+s] && in_range) picked[s] = terms[idx];
          else                                picked[s] = 1'b0;
        end
      end
      assign sums[m] = |picked;
    end
  endgenerate

endmodule

// File: rtl/ppt_macrocell.sv
module ppt_macrocell
  import ppt_pkg::*;
(
  input  logic    clk_a,
  input  logic    clk_b,
  input  logic    clr_n,
  input  logic    set_n,
  input  logic    sum,
  input  mc_cfg_t cfg,
  output logic    pin,
  output logic    fb
);

  logic d_nxt;
  logic q_r;
  logic mc_clk;

  // next-state and clock choice
  always_comb begin
    d_nxt  = sum ^ cfg.inv;
    mc_clk = (cfg.clk_src == CLK_SRC_B) ? clk_b : clk_a;
  end

  // clear outranks preset
  always_ff @(posedge mc_clk or negedge clr_n or negedge set_n) begin
    if (!clr_n)      q_r <= 1'b0;
    else if (!set_n) q_r <= 1'b1;
    else             q_r <= d_nxt;
  end

  assign pin = cfg.pin_comb ? d_nxt : q_r;
  assign fb  = cfg.fb_reg   ? q_r   : d_nxt;

endmodule

// File: rtl/ppt_logic_block.sv
module ppt_logic_block
  import ppt_pkg::*;
#(
  parameter  int N_IN  = 36,
  parameter  int N_PT  = 86,
  parameter  int N_MC  = 16,
  parameter  int SLOTS = 16,
  localparam int IDXW  = (N_PT < 2) ? 1 : $clog2(N_PT)
) (
  input  logic                      clk_a,
  input  logic                      clk_b,
  input  logic                      clr_n,
  input  logic                      set_n,
  input  logic [N_IN-1:0]           sig_in,
  input  logic [2*N_IN*N_PT-1:0]    and_cfg,
  input  logic [N_MC*SLOTS*IDXW-1:0] slot_idx,
  input  logic [N_MC*SLOTS-1:0]     slot_en,
  input  logic [N_MC-1:0]           mc_inv,
  input  logic [N_MC-1:0]           mc_pin_comb,
  input  logic [N_MC-1:0]           mc_fb_reg,
  input  logic [N_MC-1:0]           mc_clk_sel,
  output logic [N_MC-1:0]           pin_out,
  output logic [N_MC-1:0]           fb_out
);

  logic [N_PT-1:0] terms;
  logic [N_MC-1:0] sums;

  ppt_and_array #(.N_IN(N_IN), .N_PT(N_PT)) i_array (
    .sig_in  (sig_in),
    .and_cfg (and_cfg),
    .terms   (terms)
  );

  ppt_allocator #(.N_PT(N_PT), .N_MC(N_MC), .SLOTS(SLOTS), .IDXW(IDXW)) i_alloc (
    .terms    (terms),
    .slot_idx (slot_idx),
    .slot_en  (slot_en),
    .sums     (sums)
  );

  generate
    for (genvar m = 0; m < N_MC; m++) begin : g_cell
      mc_cfg_t cfg;
      always_comb begin
        cfg.inv      = mc_inv[m];
        cfg.pin_comb = mc_pin_comb[m];
        cfg.fb_reg   = mc_fb_reg[m];
        cfg.clk_src  = mc_clk_sel[m] ? CLK_SRC_B : CLK_SRC_A;
      end
      ppt_macrocell i_cell (
        .clk_a (clk_a),
        .clk_b (clk_b),
        .clr_n (clr_n),
        .set_n (set_n),
        .sum   (sums[m]),
        .cfg   (cfg),
        .pin   (pin_out[m]),
        .fb    (fb_out[m])
      );
    end
  endgenerate

endmodule

// File: rtl/ppt_logic_block_chk.sv
module ppt_logic_block_chk #(
  parameter int N_MC  = 16,
  parameter int SLOTS = 16
) (
  input logic                  clk_a,
  input logic                  clr_n,
  input logic                  set_n,
  input logic [N_MC*SLOTS-1:0] slot_en,
  input logic [N_MC-1:0]       mc_inv,
  input logic [N_MC-1:0]       mc_pin_comb,
  input logic [N_MC-1:0]       mc_fb_reg,
  input logic [N_MC-1:0]       pin_out,
  input logic [N_MC-1:0]       fb_out
);

  generate
    for (genvar m = 0; m < N_MC; m++) begin : g_chk
      // R10
      clear_wins_chk: assert property (@(negedge clk_a) disable iff (clr_n)
        !mc_pin_comb[m] |-> !pin_out[m]);

      // R11
      preset_high_chk: assert property (@(negedge clk_a) disable iff (!clr_n)
        (!set_n && !mc_pin_comb[m]) |-> pin_out[m]);

      // R3
      empty_sum_chk: assert property (@(negedge clk_a) disable iff (!clr_n)
        (slot_en[m*SLOTS +: SLOTS] == '0 && mc_pin_comb[m]) |-> (pin_out[m] == mc_inv[m]));

      // R9
      same_path_chk: assert property (@(negedge clk_a) disable iff (!clr_n)
        (mc_pin_comb[m] != mc_fb_reg[m]) |-> (fb_out[m] == pin_out[m]));
    end
  endgenerate

endmodule

bind ppt_logic_block ppt_logic_block_chk #(.N_MC(N_MC), .SLOTS(SLOTS)) i_chk (
  .clk_a       (clk_a),
  .clr_n       (clr_n),
  .set_n       (set_n),
  .slot_en     (slot_en),
  .mc_inv      (mc_inv),
  .mc_pin_comb (mc_pin_comb),
  .mc_fb_reg   (mc_fb_reg),
  .pin_out     (pin_out),
  .fb_out      (fb_out)
);

// File: tb/test_ppt_logic_block.sv
module test_ppt_logic_block;

  localparam int NI = 3;
  localparam int NP = 6;
  localparam int NM = 4;
  localparam int NS = 3;
  localparam int IW = 3;
  localparam int NC = 2 * NI;
  localparam int CLK_PERIOD = 10;

  logic clk_a, clk_b, clr_n, set_n;
  logic [NI-1:0]       sig_in;
  logic [NC*NP-1:0]    and_cfg;
  logic [NM*NS*IW-1:0] slot_idx;
  logic [NM*NS-1:0]    slot_en;
  logic [NM-1:0]       mc_inv, mc_pin_comb, mc_fb_reg, mc_clk_sel;
  logic [NM-1:0]       pin_out, fb_out;

  int n_chk = 0;
  int n_bad = 0;

  ppt_logic_block #(.N_IN(NI), .N_PT(NP), .N_MC(NM), .SLOTS(NS)) i_ppt_logic_block (
    .clk_a(clk_a), .clk_b(clk_b), .clr_n(clr_n), .set_n(set_n),
    .sig_in(sig_in), .and_cfg(and_cfg), .slot_idx(slot_idx), .slot_en(slot_en),
    .mc_inv(mc_inv), .mc_pin_comb(mc_pin_comb), .mc_fb_reg(mc_fb_reg),
    .mc_clk_sel(mc_clk_sel), .pin_out(pin_out), .fb_out(fb_out)
  );

  function automatic logic exp_term(int j, logic [NI-1:0] x);
    for (int i = 0; i < NI; i++) begin
      if (and_cfg[j*NC + 2*i]   && !x[i]) return 1'b0;
      if (and_cfg[j*NC + 2*i+1] &&  x[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic exp_val(int m, logic [NI-1:0] x);
    logic acc = 1'b0;
    for (int s = 0; s < NS; s++) begin
      int idx = int'(slot_idx[(m*NS+s)*IW +: IW]);
      if (slot_en[m*NS+s] && idx < NP) acc = acc | exp_term(idx, x);
    end
    return acc ^ mc_inv[m];
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [NM-1:0] got, input logic [NM-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic pulse_a();
    #(CLK_PERIOD/2) clk_a = 1'b1;
    #(CLK_PERIOD/2) clk_a = 1'b0;
    #1;
  endtask

  task automatic pulse_b();
    #(CLK_PERIOD/2) clk_b = 1'b1;
    #(CLK_PERIOD/2) clk_b = 1'b0;
    #1;
  endtask

  task automatic set_slot(input int m, input int s, input int idx);
    slot_idx[(m*NS+s)*IW +: IW] = IW'(idx);
    slot_en[m*NS+s] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clk_a = 1'b0; clk_b = 1'b0; clr_n = 1'b1; set_n = 1'b1;
    sig_in = '0; and_cfg = '0; slot_idx = '0; slot_en = '0;
    mc_inv = '0; mc_pin_comb = '0; mc_fb_reg = '1; mc_clk_sel = '0;
    #1 clr_n = 1'b0;
    #2;
    check_vec("R10 reset pins", pin_out, '0);
    check_vec("R10 reset fb", fb_out, '0);
    sig_in = '1;
    pulse_a();
    check_vec("R10 clear holds over clk_a edge", pin_out, '0);
    clr_n = 1'b1;
    #2;

    // random sweeps, combinational paths, all input patterns
    mc_pin_comb = '1; mc_fb_reg = '0;
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < NC*NP; k++) and_cfg[k] = ($urandom % 4) == 0;
      for (int k = 0; k < NM*NS*IW; k++) slot_idx[k] = $urandom % 2;
      for (int k = 0; k < NM*NS; k++) slot_en[k] = $urandom % 2;
      for (int k = 0; k < NM; k++) mc_inv[k] = $urandom % 2;
      for (int x = 0; x < (1 << NI); x++) begin
        sig_in = NI'(x);
        #2;
        for (int m = 0; m < NM; m++) begin
          check("R1 R3 R5 R6 sweep pin", pin_out[m], exp_val(m, NI'(x)));
          check("R9 sweep fb comb", fb_out[m], exp_val(m, NI'(x)));
        end
      end
    end

    // R2 empty term is 1, contradictory term is 0
    and_cfg = '0; slot_idx = '0; slot_en = '0; mc_inv = '0;
    set_slot(0, 0, 0);
    sig_in = 3'b010; #2;
    check("R2 empty term", pin_out[0], 1'b1);
    and_cfg[0] = 1'b1; and_cfg[1] = 1'b1;
    for (int x = 0; x < (1 << NI); x++) begin
      sig_in = NI'(x); #2;
      check("R2 both polarities", pin_out[0], 1'b0);
    end

    // R3 no slots: sum is 0, inversion gives 1
    and_cfg = '0; slot_en = '0; mc_inv = '0; #2;
    check_vec("R3 zero slots", pin_out, 4'b0000);
    mc_inv = '1; #2;
    check_vec("R3 R6 zero slots inverted", pin_out, 4'b1111);
    mc_inv = '0;

    // R4 out-of-range indices contribute nothing even though all terms are 1
    set_slot(1, 0, 6); set_slot(1, 1, 7); #2;
    check("R4 index past pool", pin_out[1], 1'b0);
    slot_en = '0;

    // R5 one term shared by every macrocell
    and_cfg[2*NC + 0] = 1'b1;
    for (int m = 0; m < NM; m++) set_slot(m, m % NS, 2);
    for (int x = 0; x < (1 << NI); x++) begin
      sig_in = NI'(x); #2;
      check_vec("R5 shared term", pin_out, {NM{x[0]}});
    end

    // registered paths: term0 = in0, term1 = in1
    and_cfg = '0; slot_en = '0; slot_idx = '0;
    and_cfg[0*NC + 0] = 1'b1;
    and_cfg[1*NC + 2] = 1'b1;
    set_slot(0, 0, 0); set_slot(1, 0, 0); set_slot(2, 0, 1); set_slot(3, 0, 1);
    mc_pin_comb = '0; mc_fb_reg = '1; mc_clk_sel = 4'b1100; mc_inv = '0;
    sig_in = '0;
    clr_n = 1'b0; #2; clr_n = 1'b1; #2;
    sig_in = 3'b011; #2;
    check_vec("R7 no change without edge", pin_out, 4'b0000);
    pulse_a();
    check_vec("R8 clk_a captures its cells only", pin_out, 4'b0011);
    pulse_b();
    check_vec("R8 clk_b captures its cells", pin_out, 4'b1111);
    sig_in = '0; #2;
    check_vec("R7 registered pin holds", pin_out, 4'b1111);
    pulse_b();
    check_vec("R8 clk_b leaves clk_a cells", pin_out, 4'b0011);
    pulse_a();
    check_vec("R8 clk_a clears its cells", pin_out, 4'b0000);

    // R9 buried register: pin combinational, feedback registered
    mc_pin_comb = '1; mc_fb_reg = '1;
    sig_in = 3'b011; #2;
    pulse_a(); pulse_b();
    sig_in = '0; #2;
    check_vec("R9 pin follows input", pin_out, 4'b0000);
    check_vec("R9 fb keeps register", fb_out, 4'b1111);
    mc_pin_comb = '0; mc_fb_reg = '0; #2;
    check_vec("R9 pin register", pin_out, 4'b1111);
    check_vec("R9 fb combinational", fb_out, 4'b0000);

    // R6 inversion ahead of the register
    mc_inv = '1; mc_fb_reg = '1;
    sig_in = 3'b011; #2;
    pulse_a(); pulse_b();
    check_vec("R6 inverted capture", pin_out, 4'b0000);
    mc_inv = '0;

    // R11 / R10 preset, then clear on top of it
    sig_in = '0;
    set_n = 1'b0; #2;
    check_vec("R11 preset drives ones", pin_out, 4'b1111);
    pulse_a();
    check_vec("R11 preset wins over edge", pin_out, 4'b1111);
    clr_n = 1'b0; #2;
    check_vec("R10 clear beats preset", pin_out, 4'b0000);
    check_vec("R10 clear beats preset fb", fb_out, 4'b0000);
    set_n = 1'b1; #2;
    clr_n = 1'b1; #2;
    check_vec("R10 after release", pin_out, 4'b0000);
    sig_in = 3'b011; #2;
    pulse_a();
    check_vec("R8 capture after release", pin_out, 4'b0011);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule